// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is the serial front end of a small byte-wide register file with ten locations (indices 0 to 9). A fast system clock samples the two bus lines through synchronizers and glitch filters. The block finds START, repeated START and STOP conditions and shifts bits in on rising SCL edges. It answers one 7-bit device address, chosen by a strap input, by pulling SDA low during the ninth clock of the address byte. It releases SDA at all other times. SDA is driven only through an output-enable that pulls the line low.

A write transfer carries a pointer byte followed by any number of data bytes. Each data byte leaves the block as a one-cycle write strobe to the pointed location, and the pointer then advances. A read transfer returns bytes from the pointed location with the same auto-advance. A plain read resumes after the last location accessed. A combined read sets the pointer first and then turns the direction with a repeated START. The register file sits outside the block and is reached through an index output, a write strobe with data, a read strobe and a combinational read-data input.

Top module: `twi_reg_slave`

## Requirements
- R1: The block acknowledges an address byte only if its upper seven bits equal 7'b0001111 (strap high) or 7'b0001000 (strap low), by raising `sda_pull` through the ninth SCL clock. A mismatched transfer is ignored until the next START: no acknowledge and no strobes.
- R2: A falling SDA while SCL is high starts a transfer, and a rising SDA while SCL is high ends it. Data bits are taken on rising SCL, MSB first, and bit 0 of the address byte selects read (1) or write (0).
- R3: In a write transfer, the first byte after the address loads the pointer. A value above 9 loads 0 instead.
- R4: Each later byte in a write transfer produces one `reg_wstb` pulse with `reg_idx` equal to the pointer and `reg_wdata` equal to the byte, and is acknowledged. The pointer advances by one at the end of that byte's acknowledge clock.
- R5: The pointer advances from 9 to 0 on both write and read.
- R6: A read transfer without a preceding pointer byte returns first the location after the last one written or read.
- R7: A combined transfer (pointer byte, repeated START, read address) returns bytes starting at the loaded pointer, advancing after each byte. Each byte is fetched with one `reg_rstb` pulse.
- R8: A START or STOP that arrives inside an address or data byte discards the partial byte with no write and no pointer change. A START followed at once by a STOP has no effect.
- R9: When the master does not acknowledge a read byte, the block stops sending and holds `sda_pull` low until the next START.
- R10: After reset `sda_pull`, `reg_wstb` and `reg_rstb` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| addr_strap | input | 1 | Selects which of the two device addresses is answered |
| sda_pull | output | 1 | 1 pulls SDA low; 0 leaves it released |
| reg_idx | output | 4 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Byte to write, valid with `reg_wstb` |
| reg_wstb | output | 1 | One-cycle write strobe |
| reg_rstb | output | 1 | One-cycle strobe when a byte is fetched for sending |
| reg_rdata | input | 8 | Contents of the location at `reg_idx` |

## Verification
Assertions check every cycle that the pointer never leaves the 0 to 9 range, that the write and fetch strobes never coincide, that the pointer holds steady through the cycle after a write strobe, that SDA is released whenever the block is idle, and that a filtered line changes only to a level its synchronizer had already settled on. Address matching for both strap settings, pointer forcing and wrap-around, resumption of plain reads, repeated-START turnaround, abort on mid-byte START or STOP, and release after a master's not-acknowledge need whole bus transactions, so only the bench's scenarios show them. A scoreboard compares every write strobe with the expected location and byte.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
// Shared constants and the protocol state type for the two-wire slave.
// Assumes a 7-bit device address and byte-wide registers.
package twi_pkg;
    localparam logic [6:0] DEV_ID_STRAP_HI = 7'b0001111;
    localparam logic [6:0] DEV_ID_STRAP_LO = 7'b0001000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK
    } twi_state_t;
endpackage

// File: rtl/twi_glitch_filter.sv
`timescale 1ns/1ps
// Brings one bus line into the clock domain with two flops, then passes a
// new level only after it has held for STAGES consecutive clocks.
// Assumes the line idles high (reset value 1).
module twi_glitch_filter #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(STAGES + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] hold_cnt;

    // Synchronize, then count how long the synchronized level differs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q   <= 2'b11;
            hold_cnt <= '0;
            clean    <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == clean) begin
                hold_cnt <= '0;
            end else if (hold_cnt == CW'(STAGES - 1)) begin
                clean    <= sync_q[1];
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    // R2: a filtered change always follows the synchronized level.
    assert_filter_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean) |-> (clean == $past(sync_q[1])));
endmodule

// File: rtl/twi_bus_events.sv
`timescale 1ns/1ps
// Turns filtered SCL/SDA levels into single-cycle events: START, STOP,
// SCL rising and SCL falling. Assumes both inputs come through equal filters.
module twi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_d, sda_d;

    // Remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    // SDA moving while SCL stays high marks a bus condition.
    always_comb begin
        start_ev = scl & scl_d & sda_d & ~sda;
        stop_ev  = scl & scl_d & ~sda_d & sda;
        scl_rise = scl & ~scl_d;
        scl_fall = ~scl & scl_d;
    end
endmodule

// File: rtl/twi_protocol.sv
`timescale 1ns/1ps
// Byte-level protocol engine: address match, acknowledge, pointer handling,
// write strobes and read shifting. Assumes single-cycle events from
// twi_bus_events and a combinational register read path.
module twi_protocol
    import twi_pkg::*;
#(
    parameter int NUM_REGS = 10,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_s,
    input  logic             addr_strap,
    input  logic [7:0]       reg_rdata,
    output logic [IDX_W-1:0] reg_idx,
    output logic [7:0]       reg_wdata,
    output logic             reg_wstb,
    output logic             reg_rstb,
    output logic             sda_pull
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);
    localparam logic [7:0]       LAST_B   = 8'(NUM_REGS - 1);

    twi_state_t       state;
    logic [7:0]       shreg;
    logic [2:0]       bit_cnt;
    logic             byte_full;
    logic             rd_dir;
    logic             ptr_phase;
    logic             master_nack;
    logic [IDX_W-1:0] ptr_next;
    logic [6:0]       my_id;

    // Wrap-around successor of the pointer and the device address in use.
    always_comb begin
        ptr_next = (reg_idx == LAST_IDX) ? '0 : reg_idx + 1'b1;
        my_id    = addr_strap ? DEV_ID_STRAP_HI : DEV_ID_STRAP_LO;
    end

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            shreg       <= '0;
            bit_cnt     <= '0;
            byte_full   <= 1'b0;
            rd_dir      <= 1'b0;
            ptr_phase   <= 1'b0;
            master_nack <= 1'b0;
            reg_idx     <= '0;
            reg_wdata   <= '0;
            reg_wstb    <= 1'b0;
            reg_rstb    <= 1'b0;
            sda_pull    <= 1'b0;
        end else begin
            reg_wstb <= 1'b0;
            reg_rstb <= 1'b0;
            if (start_ev) begin
                state     <= ST_ADDR;
                bit_cnt   <= '0;
                byte_full <= 1'b0;
                sda_pull  <= 1'b0;
            end else if (stop_ev) begin
                state     <= ST_IDLE;
                byte_full <= 1'b0;
                sda_pull  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WBYTE: begin
                        if (scl_rise && !byte_full) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 3'd7) byte_full <= 1'b1;
                        end
                        if (scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            bit_cnt   <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == my_id) begin
                                    sda_pull  <= 1'b1;
                                    rd_dir    <= shreg[0];
                                    ptr_phase <= ~shreg[0];
                                    state     <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_pull <= 1'b1;
                                state    <= ST_WACK;
                                if (ptr_phase) begin
                                    reg_idx <= (shreg > LAST_B) ? '0 : shreg[IDX_W-1:0];
                                end else begin
                                    reg_wstb  <= 1'b1;
                                    reg_wdata <= shreg;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rd_dir) begin
                                shreg    <= reg_rdata;
                                reg_rstb <= 1'b1;
                                sda_pull <= ~reg_rdata[7];
                                state    <= ST_RBYTE;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_WBYTE;
                            end
                            bit_cnt <= '0;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_pull  <= 1'b0;
                            state     <= ST_WBYTE;
                            if (!ptr_phase) reg_idx <= ptr_next;
                            ptr_phase <= 1'b0;
                        end
                    end
                    ST_RBYTE: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 3'd7) byte_full <= 1'b1;
                        end
                        if (scl_fall) begin
                            if (byte_full) begin
                                byte_full <= 1'b0;
                                sda_pull  <= 1'b0;
                                reg_idx   <= ptr_next;
                                state     <= ST_RACK;
                            end else begin
                                shreg    <= {shreg[6:0], 1'b0};
                                sda_pull <= ~shreg[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) master_nack <= sda_s;
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (master_nack) begin
                                state <= ST_IDLE;
                            end else begin
                                shreg    <= reg_rdata;
                                reg_rstb <= 1'b1;
                                sda_pull <= ~reg_rdata[7];
                                state    <= ST_RBYTE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: the pointer never addresses a missing register.
    assert_ptr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_idx <= LAST_IDX);
    // R4: the written location holds still in the cycle after the strobe.
    assert_wr_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wstb |=> $stable(reg_idx));
    // R7: a fetch and a write never share a cycle.
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wstb && reg_rstb));
    // R9: an idle slave leaves SDA released and writes nothing.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sda_pull && !reg_wstb));
endmodule

// File: rtl/twi_reg_slave.sv
`timescale 1ns/1ps
// Top of the two-wire register slave: filters both bus lines, derives bus
// events and runs the protocol engine toward an external register file.
// Assumes clk runs at least ~20x the SCL rate so filtering keeps up.
module twi_reg_slave #(
    parameter int NUM_REGS    = 10,
    parameter int FILT_STAGES = 3,
    parameter int IDX_W       = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             addr_strap,
    output logic             sda_pull,
    output logic [IDX_W-1:0] reg_idx,
    output logic [7:0]       reg_wdata,
    output logic             reg_wstb,
    output logic             reg_rstb,
    input  logic [7:0]       reg_rdata
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean_lines;
    logic start_ev, stop_ev, scl_rise, scl_fall;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        twi_glitch_filter #(.STAGES(FILT_STAGES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    twi_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (clean_lines[0]),
        .sda      (clean_lines[1]),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    twi_protocol #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_proto (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_s      (clean_lines[1]),
        .addr_strap (addr_strap),
        .reg_rdata  (reg_rdata),
        .reg_idx    (reg_idx),
        .reg_wdata  (reg_wdata),
        .reg_wstb   (reg_wstb),
        .reg_rstb   (reg_rstb),
        .sda_pull   (sda_pull)
    );
endmodule

// File: tb/twi_reg_slave_test.sv
`timescale 1ns/1ps
// Scoreboard bench: bus-master tasks push expected writes into a queue,
// a monitor pops and compares them on every write strobe.
module twi_reg_slave_test;
    localparam time T = 400ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b1;
    logic sda_pull, reg_wstb, reg_rstb;
    logic [3:0] reg_idx;
    logic [7:0] reg_wdata, reg_rdata;
    logic bus_sda;
    logic [7:0] regs [10];
    logic [7:0] exp_regs [10];
    logic [3:0] exp_ptr = 4'd0;
    logic [11:0] exp_q [$];
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    assign bus_sda = sda_m & ~sda_pull;
    assign reg_rdata = (reg_idx < 4'd10) ? regs[reg_idx] : 8'h00;

    twi_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(bus_sda),
        .addr_strap(strap), .sda_pull(sda_pull), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_wstb(reg_wstb), .reg_rstb(reg_rstb),
        .reg_rdata(reg_rdata)
    );

    // Register file seen by the block.
    always @(posedge clk) if (reg_wstb && reg_idx < 4'd10) regs[reg_idx] <= reg_wdata;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: each write strobe must match the oldest expected write (R4).
    always @(negedge clk) begin
        if (rst_n && reg_wstb) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected write", {reg_idx, reg_wdata}, 0);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                chk({reg_idx, reg_wdata} == e, "R4 write", {reg_idx, reg_wdata}, e);
            end
        end
    end

    function automatic logic [3:0] wrap(input logic [3:0] p);
        return (p == 4'd9) ? 4'd0 : p + 4'd1;
    endfunction

    task automatic m_start();
        sda_m = 1'b1; #(T); scl_m = 1'b1; #(T); sda_m = 1'b0; #(T); scl_m = 1'b0; #(T/4);
    endtask
    task automatic m_stop();
        sda_m = 1'b0; #(T); scl_m = 1'b1; #(T); sda_m = 1'b1; #(T);
    endtask
    task automatic m_bit(input logic b, output logic r);
        sda_m = b; #(T); scl_m = 1'b1; #(T/2); r = bus_sda; #(T/2); scl_m = 1'b0; #(T/4);
    endtask
    task automatic m_wbyte(input logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(b[i], r);
        m_bit(1'b1, r);
        acked = ~r;
    endtask
    task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin m_bit(1'b1, r); d[i] = r; end
        m_bit(~give_ack, r);
    endtask

    // Address byte plus acknowledge check.
    task automatic m_addr(input logic [6:0] id, input logic rw, input logic want, input string tag);
        logic a;
        m_wbyte({id, rw}, a);
        chk(a == want, tag, a, want);
    endtask
    // Pointer byte, then data bytes base, base+step, ...
    task automatic m_ptr(input logic [7:0] p, input string tag);
        logic a;
        m_wbyte(p, a);
        chk(a, tag, a, 1);
        exp_ptr = (p > 8'd9) ? 4'd0 : p[3:0];
    endtask
    task automatic m_data(input logic [7:0] d, input string tag);
        logic a;
        exp_q.push_back({exp_ptr, d});
        exp_regs[exp_ptr] = d;
        exp_ptr = wrap(exp_ptr);
        m_wbyte(d, a);
        chk(a, tag, a, 1);
    endtask
    task automatic m_reads(input int n, input string tag);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            m_rbyte(i != n - 1, d);
            chk(d == exp_regs[exp_ptr], tag, d, exp_regs[exp_ptr]);
            exp_ptr = wrap(exp_ptr);
        end
    endtask

    initial begin
        for (int i = 0; i < 10; i++) begin regs[i] = 8'hA0 + 8'(i); exp_regs[i] = 8'hA0 + 8'(i); end
        repeat (4) @(posedge clk);
        #1;
        // R10: reset state.
        chk(!sda_pull && !reg_wstb && !reg_rstb, "R10 outputs idle", {sda_pull, reg_wstb, reg_rstb}, 0);
        chk(reg_idx == 4'd0, "R10 pointer", reg_idx, 0);
        rst_n = 1'b1;
        repeat (10) @(posedge clk);

        // R1/R3/R4: write with strap high.
        m_start(); m_addr(7'h0F, 1'b0, 1'b1, "R1 ack strap high");
        m_ptr(8'h03, "R3 ptr ack"); m_data(8'h11, "R4 ack"); m_data(8'h22, "R4 ack");
        m_stop();

        // R7: combined read from 3.
        m_start(); m_addr(7'h0F, 1'b0, 1'b1, "R7 addr w");
        m_ptr(8'h03, "R7 ptr");
        m_start(); m_addr(7'h0F, 1'b1, 1'b1, "R7 addr r");
        m_reads(2, "R7 read data");
        m_stop();

        // R6: plain read resumes at 5.
        m_start(); m_addr(7'h0F, 1'b1, 1'b1, "R6 addr r");
        m_reads(1, "R6 read data");
        m_stop();

        // R5: write wraps 9 -> 0, then combined read across the wrap.
        m_start(); m_addr(7'h0F, 1'b0, 1'b1, "R5 addr w");
        m_ptr(8'h09, "R5 ptr"); m_data(8'h33, "R5 ack"); m_data(8'h44, "R5 ack");
        m_stop();
        m_start(); m_addr(7'h0F, 1'b0, 1'b1, "R5 addr w2");
        m_ptr(8'h08, "R5 ptr2");
        m_start(); m_addr(7'h0F, 1'b1, 1'b1, "R5 addr r");
        m_reads(3, "R5 read wrap");
        // R9: after the master's not-acknowledge SDA stays released.
        for (int i = 0; i < 4; i++) begin
            #(T/2);
            chk(!sda_pull, "R9 released after nack", sda_pull, 0);
        end
        m_stop();

        // R3: pointer above 9 is forced to 0.
        m_start(); m_addr(7'h0F, 1'b0, 1'b1, "R3 addr w");
        m_ptr(8'h0C, "R3 ptr oor"); m_data(8'h55, "R3 write at 0");
        m_stop();

        // R1: the other address is ignored while the strap is high.
        m_start(); m_addr(7'h08, 1'b0, 1'b0, "R1 mismatch nack");
        begin
            logic a;
            m_wbyte(8'h02, a);
            chk(!a, "R1 ignored byte", a, 0);
        end
        m_stop();

        // R1: strap low answers 0001000.
        strap = 1'b0;
        m_start(); m_addr(7'h08, 1'b0, 1'b1, "R1 ack strap low");
        m_ptr(8'h07, "R1 ptr"); m_data(8'h66, "R1 data");
        m_stop();

        // R8: STOP inside a data byte discards it; pointer stays 2.
        m_start(); m_addr(7'h08, 1'b0, 1'b1, "R8 addr w");
        m_ptr(8'h02, "R8 ptr");
        begin
            logic r;
            for (int i = 0; i < 4; i++) m_bit(1'b1, r);
        end
        m_stop();
        m_start(); m_addr(7'h08, 1'b1, 1'b1, "R8 addr r");
        m_reads(1, "R8 ptr kept after abort");
        m_stop();

        // R8: START inside an address byte restarts cleanly.
        m_start();
        begin
            logic r;
            for (int i = 0; i < 3; i++) m_bit(1'b0, r);
        end
        m_start(); m_addr(7'h08, 1'b0, 1'b1, "R8 restart addr");
        m_ptr(8'h06, "R8 ptr2"); m_data(8'h77, "R8 data after restart");
        m_stop();

        // R2: START followed at once by STOP has no effect; next read works.
        m_start(); m_stop();
        m_start(); m_addr(7'h08, 1'b1, 1'b1, "R2 addr after start-stop");
        m_reads(2, "R2 read after start-stop");
        m_stop();

        repeat (50) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
        for (int i = 0; i < 10; i++)
            chk(regs[i] == exp_regs[i], "R4 final contents", regs[i], exp_regs[i]);
        finished = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (finished);
            begin
                repeat (190000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule